// File: doc/BRIEF.md
# Radix-Configurable Add-Compare-Select Unit

This block is the per-state processor of a trellis decoder for linear block codes. In one cycle it receives the metrics of all predecessor states that merge into its state, together with one correlation metric for each incoming composite branch. It adds each branch metric to the metric of the state the branch leaves. It then finds the largest sum through a balanced tree of two-way comparisons. Finally it registers that sum as the new state metric, along with the index of the branch that survived.

The number of merging composite branches is a power of two, 2^DELTA. Eight-way and sixteen-way merges are both reached through that parameter. When PBITS is 1, every composite branch stands for two parallel branches whose labels are complements of each other. Only one correlation metric is supplied for such a pair. The unit forms the metric of the other branch by negating it, keeps the better of the two, and records which one it kept. When PIPE is 1, a register follows every level of the comparison tree. When PIPE is 0, the tree is purely combinational. In both cases a final output register holds the result.

Raising the block-start input makes every predecessor metric count as zero. This is how the originating state of a subtrellis starts a new block.

Top module: `acs_unit`

## Requirements
- R1: While reset is held, and directly after it is released, out_valid is 0.
- R2: out_valid goes high exactly LAT = (PIPE ? DELTA : 0) + 1 cycles after a cycle with in_valid high. It stays high for one cycle per accepted input, and back-to-back inputs give back-to-back results in input order.
- R3: With PBITS = 1, a composite branch whose metric b is negative contributes -b and reports parallel bit 1. A branch with b >= 0 (zero included) contributes b and reports parallel bit 0.
- R4: Each candidate sum is the predecessor metric plus the contributed branch metric in 9-bit two's complement, clamped to [-256, 255]. It is exact at the extremes: predecessor 127 with branch metric -128 gives 255.
- R5: new_metric is the largest candidate sum of the accepted input.
- R6: When several candidate sums equal the maximum, the branch with the lowest composite index survives.
- R7: surv_idx holds the surviving composite index in bits [DELTA+PBITS-1:PBITS] and, when PBITS = 1, the parallel bit in bit 0.
- R8: When blk_start is high with in_valid, all predecessor metrics are taken as zero, so the result depends only on the branch metrics.
- R9: new_metric and surv_idx keep their values in every cycle in which out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies the metric vectors in this cycle |
| blk_start | input | 1 | Treat all predecessor metrics as zero |
| pred_metrics | input | RADIX*8 | Signed predecessor state metrics, branch i in bits [8i+7:8i] |
| branch_metrics | input | RADIX*8 | Signed correlation metric per composite branch, same layout |
| out_valid | output | 1 | New result present |
| new_metric | output | 9 | Signed best sum |
| surv_idx | output | DELTA+PBITS | Surviving composite index and parallel bit |

## Verification
The checker assumes that in_valid and the metric vectors are driven from the clock domain and stable around the rising edge. It also assumes that reset is applied once before the first input, so its delay line of candidate sums lines up with the tree's own pipeline. The bench changes inputs only on falling edges and drives in_valid only after reset. The vectors it uses stay within the 8-bit signed range, and they cover negative branch metrics, zero metrics, -128, ties and back-to-back streams. No single input pattern leans on the saturation clamp, because with these widths the sums can never reach it.

// File: rtl/acs_pkg.sv
package acs_pkg;
  localparam int MW = 8;
  localparam int SW = MW + 1;

  typedef logic signed [MW-1:0] metric_t;
  typedef logic signed [SW-1:0] sum_t;

  typedef struct packed {
    sum_t eff;
    logic flip;
  } pair_t;

  // Resolve a complementary pair: the better of +bm and -bm.
  function automatic pair_t resolve_pair(metric_t bm, bit use_pair);
    pair_t r;
    r.eff  = sum_t'(bm);
    r.flip = 1'b0;
    if (use_pair && bm[MW-1]) begin
      r.eff  = -sum_t'(bm);
      r.flip = 1'b1;
    end
    return r;
  endfunction

  // Signed add with clamp to the SW-bit range.
  function automatic sum_t sat_add(sum_t a, sum_t b);
    logic signed [SW:0] w;
    w = {a[SW-1], a} + {b[SW-1], b};
    if (w[SW] != w[SW-1])
      return w[SW] ? {1'b1, {(SW-1){1'b0}}} : {1'b0, {(SW-1){1'b1}}};
    return w[SW-1:0];
  endfunction

  // Strictly greater: an equal challenger never displaces the incumbent.
  function automatic bit beats(sum_t challenger, sum_t incumbent);
    return challenger > incumbent;
  endfunction
endpackage

// File: rtl/acs_branch_add.sv
module acs_branch_add
  import acs_pkg::*;
#(
  parameter int PBITS = 1
) (
  input  metric_t sm,
  input  metric_t bm,
  input  logic    zero_pred,
  output sum_t    sum,
  output logic    par
);
  pair_t pr;
  sum_t  base;

  always_comb begin
    pr   = resolve_pair(bm, PBITS > 0);
    base = zero_pred ? '0 : sum_t'(sm);
    sum  = sat_add(base, pr.eff);
    par  = pr.flip;
  end
endmodule

// File: rtl/acs_cmp_tree.sv
module acs_cmp_tree
  import acs_pkg::*;
#(
  parameter int DELTA = 3,
  parameter int PBITS = 1,
  parameter int PIPE  = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_v,
  input  logic [(1<<DELTA)*SW-1:0] leaf_m,
  input  logic [(1<<DELTA)-1:0]   leaf_par,
  output logic                    out_v,
  output sum_t                    best_m,
  output logic [DELTA+PBITS-1:0]  best_ix
);
  localparam int RADIX = 1 << DELTA;
  localparam int IW    = DELTA + PBITS;

  for (genvar l = 0; l <= DELTA; l++) begin : lvl
    localparam int N = RADIX >> l;
    sum_t          m  [N];
    logic [IW-1:0] ix [N];
    logic          v;

    if (l == 0) begin : g_leaf
      always_comb begin
        for (int n = 0; n < N; n++) begin
          m[n]  = sum_t'(leaf_m[n*SW +: SW]);
          ix[n] = (PBITS > 0) ? IW'((n << PBITS) | int'(leaf_par[n])) : IW'(n);
        end
      end
      assign v = in_v;
    end else begin : g_node
      sum_t          mn  [N];
      logic [IW-1:0] ixn [N];
      always_comb begin
        for (int n = 0; n < N; n++) begin
          if (beats(lvl[l-1].m[2*n+1], lvl[l-1].m[2*n])) begin
            mn[n]  = lvl[l-1].m[2*n+1];
            ixn[n] = lvl[l-1].ix[2*n+1];
          end else begin
            mn[n]  = lvl[l-1].m[2*n];
            ixn[n] = lvl[l-1].ix[2*n];
          end
        end
      end
      if (PIPE != 0) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) v <= 1'b0;
          else        v <= lvl[l-1].v;
        end
        always_ff @(posedge clk) begin
          if (lvl[l-1].v) begin
            m  <= mn;
            ix <= ixn;
          end
        end
      end else begin : g_comb
        assign v = lvl[l-1].v;
        always_comb begin
          m  = mn;
          ix = ixn;
        end
      end
    end
  end

  assign out_v   = lvl[DELTA].v;
  assign best_m  = lvl[DELTA].m[0];
  assign best_ix = lvl[DELTA].ix[0];
endmodule

// File: rtl/acs_unit.sv
module acs_unit
  import acs_pkg::*;
#(
  parameter int DELTA = 3,
  parameter int PBITS = 1,
  parameter int PIPE  = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic                       blk_start,
  input  logic [(1<<DELTA)*MW-1:0]   pred_metrics,
  input  logic [(1<<DELTA)*MW-1:0]   branch_metrics,
  output logic                       out_valid,
  output logic [SW-1:0]              new_metric,
  output logic [DELTA+PBITS-1:0]     surv_idx
);
  localparam int RADIX = 1 << DELTA;
  localparam int IW    = DELTA + PBITS;

  // Named internal events, observed by the bound checker.
  logic [RADIX*SW-1:0] leaf_sum_flat;
  logic [RADIX-1:0]    leaf_par;
  logic                tree_v;
  sum_t                tree_m;
  logic [IW-1:0]       tree_ix;

  for (genvar g = 0; g < RADIX; g++) begin : g_br
    acs_branch_add #(.PBITS(PBITS)) u_add (
      .sm       (pred_metrics[g*MW +: MW]),
      .bm       (branch_metrics[g*MW +: MW]),
      .zero_pred(blk_start),
      .sum      (leaf_sum_flat[g*SW +: SW]),
      .par      (leaf_par[g])
    );
  end

  acs_cmp_tree #(.DELTA(DELTA), .PBITS(PBITS), .PIPE(PIPE)) u_tree (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_v    (in_valid),
    .leaf_m  (leaf_sum_flat),
    .leaf_par(leaf_par),
    .out_v   (tree_v),
    .best_m  (tree_m),
    .best_ix (tree_ix)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      new_metric <= '0;
      surv_idx   <= '0;
    end else begin
      out_valid <= tree_v;
      if (tree_v) begin
        new_metric <= tree_m;
        surv_idx   <= tree_ix;
      end
    end
  end
endmodule

// File: rtl/acs_unit_chk.sv
module acs_unit_chk
  import acs_pkg::*;
#(
  parameter int DELTA = 3,
  parameter int PBITS = 1,
  parameter int PIPE  = 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic [(1<<DELTA)*SW-1:0] leaf_sum_flat,
  input logic [(1<<DELTA)-1:0]    leaf_par,
  input logic                     out_valid,
  input logic [SW-1:0]            new_metric,
  input logic [DELTA+PBITS-1:0]   surv_idx
);
  localparam int RADIX = 1 << DELTA;
  localparam int IW    = DELTA + PBITS;
  localparam int LAT   = (PIPE != 0 ? DELTA : 0) + 1;

  logic                v_d   [LAT];
  logic [RADIX*SW-1:0] sum_d [LAT];
  logic [RADIX-1:0]    par_d [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < LAT; k++) v_d[k] <= 1'b0;
    end else begin
      v_d[0] <= in_valid;
      for (int k = 1; k < LAT; k++) v_d[k] <= v_d[k-1];
    end
  end

  always_ff @(posedge clk) begin
    sum_d[0] <= leaf_sum_flat;
    par_d[0] <= leaf_par;
    for (int k = 1; k < LAT; k++) begin
      sum_d[k] <= sum_d[k-1];
      par_d[k] <= par_d[k-1];
    end
  end

  logic [DELTA-1:0] sel;
  sum_t             om;
  sum_t             sel_sum;
  assign sel     = surv_idx[IW-1 -: DELTA];
  assign om      = sum_t'(new_metric);
  assign sel_sum = sum_t'(sum_d[LAT-1][sel*SW +: SW]);

  // R2: one result per accepted input, LAT cycles later
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == v_d[LAT-1]);

  // R4 / R7: reported metric is the candidate sum at the reported index
  p_pick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> om == sel_sum);

  // R9: outputs hold when no result is presented
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(new_metric) && $stable(surv_idx)));

  if (PBITS > 0) begin : g_par
    // R3: parallel bit matches the pair resolution of the chosen branch
    p_parbit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> surv_idx[0] == par_d[LAT-1][sel]);
  end

  for (genvar g = 0; g < RADIX; g++) begin : g_each
    sum_t gs;
    assign gs = sum_t'(sum_d[LAT-1][g*SW +: SW]);
    // R5: no candidate exceeds the chosen metric
    p_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> gs <= om);
    // R6: every lower-indexed candidate is strictly smaller
    p_tie_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (int'(sel) > g)) |-> gs < om);
  end
endmodule

bind acs_unit acs_unit_chk #(.DELTA(DELTA), .PBITS(PBITS), .PIPE(PIPE)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .leaf_sum_flat(leaf_sum_flat),
  .leaf_par     (leaf_par),
  .out_valid    (out_valid),
  .new_metric   (new_metric),
  .surv_idx     (surv_idx)
);

// File: tb/acs_unit_tb.sv
module acs_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DELTA = 3;
  localparam int PBITS = 1;
  localparam int PIPE  = 1;
  localparam int RADIX = 1 << DELTA;
  localparam int IW    = DELTA + PBITS;
  localparam int LAT   = (PIPE != 0 ? DELTA : 0) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic blk_start = 1'b0;
  logic [RADIX*8-1:0] pred_metrics = '0;
  logic [RADIX*8-1:0] branch_metrics = '0;
  logic out_valid;
  logic [8:0] new_metric;
  logic [IW-1:0] surv_idx;

  int n_chk = 0;
  int n_fail = 0;
  int smv [RADIX];
  int bmv [RADIX];

  always #(CLK_PERIOD/2) clk = ~clk;

  acs_unit #(.DELTA(DELTA), .PBITS(PBITS), .PIPE(PIPE)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .blk_start(blk_start),
    .pred_metrics(pred_metrics), .branch_metrics(branch_metrics),
    .out_valid(out_valid), .new_metric(new_metric), .surv_idx(surv_idx)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference: pick the largest sum, lowest index on a tie.
  task automatic model(bit start, output int em, output int ei);
    int best = -100000;
    em = 0; ei = 0;
    for (int i = 0; i < RADIX; i++) begin
      int eff = bmv[i];
      int p = 0;
      int s;
      if (bmv[i] < 0) begin eff = -bmv[i]; p = 1; end
      s = (start ? 0 : smv[i]) + eff;
      if (s > 255) s = 255;
      if (s < -256) s = -256;
      if (s > best) begin best = s; ei = i * 2 + p; end
    end
    em = best;
  endtask

  task automatic load(bit start);
    for (int i = 0; i < RADIX; i++) begin
      pred_metrics[i*8 +: 8]   = 8'(smv[i]);
      branch_metrics[i*8 +: 8] = 8'(bmv[i]);
    end
    blk_start = start;
    in_valid = 1'b1;
  endtask

  task automatic check_out(string req, int em, int ei);
    chk(out_valid == 1'b1, req, "out_valid", int'(out_valid), 1);
    chk(int'($signed(new_metric)) == em, req, "new_metric", int'($signed(new_metric)), em);
    chk(int'(surv_idx) == ei, req, "surv_idx", int'(surv_idx), ei);
  endtask

  task automatic run_one(string req, bit start);
    int em, ei;
    model(start, em, ei);
    @(negedge clk);
    load(start);
    @(negedge clk);
    in_valid = 1'b0;
    blk_start = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    check_out(req, em, ei);
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
  endtask

  task automatic t_basic;
    for (int i = 0; i < RADIX; i++) begin smv[i] = i * 10 - 30; bmv[i] = 20 - i * 3; end
    run_one("R5", 1'b0);
  endtask

  task automatic t_flip;
    for (int i = 0; i < RADIX; i++) begin smv[i] = 0; bmv[i] = 5; end
    bmv[3] = -100;
    run_one("R3", 1'b0);
    chk(surv_idx == 4'd7, "R7", "index layout", int'(surv_idx), 7);
  endtask

  task automatic t_zero_bm;
    for (int i = 0; i < RADIX; i++) begin smv[i] = -50; bmv[i] = 0; end
    smv[6] = 40;
    run_one("R3", 1'b0);
  endtask

  task automatic t_tie;
    for (int i = 0; i < RADIX; i++) begin smv[i] = -20; bmv[i] = 1; end
    smv[2] = 30; smv[5] = 20; bmv[5] = -11;
    run_one("R6", 1'b0);
    for (int i = 0; i < RADIX; i++) begin smv[i] = 7; bmv[i] = 7; end
    run_one("R6", 1'b0);
  endtask

  task automatic t_extreme;
    for (int i = 0; i < RADIX; i++) begin smv[i] = -128; bmv[i] = 0; end
    smv[7] = 127; bmv[7] = -128;
    run_one("R4", 1'b0);
    for (int i = 0; i < RADIX; i++) begin smv[i] = -128; bmv[i] = 0; end
    run_one("R4", 1'b0);
  endtask

  task automatic t_start;
    for (int i = 0; i < RADIX; i++) begin smv[i] = -90; bmv[i] = i; end
    smv[0] = 120;
    bmv[4] = -60;
    run_one("R8", 1'b1);
  endtask

  task automatic t_latency;
    for (int i = 0; i < RADIX; i++) begin smv[i] = i; bmv[i] = 2; end
    @(negedge clk);
    load(1'b0);
    for (int c = 1; c <= LAT + 1; c++) begin
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == (c == LAT), "R2", "valid timing", int'(out_valid), int'(c == LAT));
    end
  endtask

  task automatic t_stream;
    int em [4];
    int ei [4];
    for (int c = 0; c < 4 + LAT; c++) begin
      @(negedge clk);
      if (c >= LAT) check_out("R2", em[c-LAT], ei[c-LAT]);
      if (c < 4) begin
        for (int i = 0; i < RADIX; i++) begin
          smv[i] = (i * 17 + c * 31) % 200 - 100;
          bmv[i] = (i * 29 + c * 13) % 256 - 128;
        end
        model(1'b0, em[c], ei[c]);
        load(1'b0);
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic t_hold;
    int m0, i0;
    for (int i = 0; i < RADIX; i++) begin smv[i] = 3 * i; bmv[i] = -i; end
    run_one("R9", 1'b0);
    m0 = int'($signed(new_metric));
    i0 = int'(surv_idx);
    for (int i = 0; i < RADIX; i++) begin
      pred_metrics[i*8 +: 8] = 8'(100 - i);
      branch_metrics[i*8 +: 8] = 8'(i * 9);
    end
    repeat (LAT + 2) @(negedge clk);
    chk(out_valid == 1'b0, "R9", "no valid while idle", int'(out_valid), 0);
    chk(int'($signed(new_metric)) == m0, "R9", "metric held", int'($signed(new_metric)), m0);
    chk(int'(surv_idx) == i0, "R9", "index held", int'(surv_idx), i0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset();
    t_basic();
    t_flip();
    t_zero_bm();
    t_tie();
    t_extreme();
    t_start();
    t_latency();
    t_stream();
    t_hold();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule